// File: doc/BRIEF.md
# Word Program Engine with Hardware Sequence Flags

This block is the flash-side command interpreter and automatic program engine for a small word-organised array held in registers. Software programs one word by sending four bus writes: three unlock writes to fixed addresses, then the target word written to its even address. After that, the engine runs a timed internal program operation, and the bus interface stops accepting commands until it ends.

While the operation runs, a read does not return array data. It returns a status word. That word carries a data-polling bit, a toggle bit and a timeout bit. Programming can only clear bits. A word that would need a 0-to-1 change never completes. After a fixed limit the engine raises the timeout bit and stays in flag mode until a reset command or a hardware reset. The program time and the limit are parameters.

Addresses are byte addresses, and word index = address >> 1. Unlock address A defaults to 0x14 and unlock address B defaults to 0x0A. Command bytes are compared on the low eight data bits.

Top module: `flash_prog_top`

## Requirements
- R1: A program operation starts only on the fourth write of the sequence: A/0xAA, then B/0x55, then A/0xA0, then data to an even target address. busy_o rises at that fourth edge. If no bit must go from 0 to 1, busy_o stays high for exactly PROG_CYCLES cycles.
- R2: If the address or data in cycles 1 to 3 does not match, the decoder returns to read mode with no side effect. A later single write then changes nothing.
- R3: If the fourth write goes to an odd address, the sequence is abandoned. Nothing is programmed and busy_o stays low.
- R4: The stored word is the bitwise AND of the old word and the written word.
- R5: If the written word needs a 0-to-1 change, busy_o stays high for LIMIT_CYCLES cycles. The engine then enters flag mode and the target word holds the AND of the old and written words.
- R6: While busy, a read returns a status word. Bit 7 is the inverse of bit 7 of the written data, bit 6 is the toggle bit, and bit 5 is 0. All other bits are 0. rdata_o is registered: it is valid the cycle after the read strobe and reflects the state before that edge.
- R7: While busy, bit 6 inverts after every read strobe. It starts at 0 for each operation.
- R8: In flag mode, reads return bit 5 = 1, with bit 6 frozen and bit 7 still inverted. A write whose low byte is 0xF0 returns to read mode. Any other write is ignored.
- R9: While busy, all bus writes are ignored, including complete command sequences.
- R10: An asynchronous hardware reset (rst_ni low) sets every word to all ones, returns to read mode, and clears busy_o and rdata_o. This also applies during an operation.
- R11: In read mode, a read returns the stored word at the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | DATA_W | Registered read data or status word |
| busy_o | output | 1 | Program operation running |

## Verification
Two functions can fall in the same cycle: a read strobe and the end of the program operation. The bench provokes this by placing a read exactly on the completion edge. It counts the cycles from the fourth command write so that the strobe lands on the edge where busy_o falls. That read must still return the status word with the toggle value held before the edge, and the next read must return the stored word. A hardware reset asserted mid-operation is judged by busy_o dropping at once and by a following read that returns erased array data, not flags.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_TGT, ST_RUN, ST_TMO
  } fsm_e;

  localparam logic [7:0] CMD_UNL1 = 8'hAA;
  localparam logic [7:0] CMD_UNL2 = 8'h55;
  localparam logic [7:0] CMD_PROG = 8'hA0;
  localparam logic [7:0] CMD_RST  = 8'hF0;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
  localparam int unsigned BIT_TMO  = 5;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned UNLOCK_A = 20,
  parameter int unsigned UNLOCK_B = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_ok_i,
  input  logic              done_tmo_i,
  output fsm_e              state_o,
  output logic              start_o,
  output logic [IDX_W-1:0]  tgt_idx_o,
  output logic [DATA_W-1:0] tgt_data_o
);
  localparam logic [ADDR_W-1:0] UA = ADDR_W'(UNLOCK_A);
  localparam logic [ADDR_W-1:0] UB = ADDR_W'(UNLOCK_B);

  fsm_e state_q, state_d;
  logic [7:0] cmd_byte;

  assign cmd_byte = wdata_i[7:0];
  assign start_o  = (state_q == ST_TGT) && we_i && !addr_i[0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_READ: if (we_i && addr_i == UA && cmd_byte == CMD_UNL1) state_d = ST_UNL1;
      ST_UNL1: if (we_i) state_d = (addr_i == UB && cmd_byte == CMD_UNL2) ? ST_UNL2 : ST_READ;
      ST_UNL2: if (we_i) state_d = (addr_i == UA && cmd_byte == CMD_PROG) ? ST_TGT : ST_READ;
      ST_TGT:  if (we_i) state_d = start_o ? ST_RUN : ST_READ;
      ST_RUN: begin
        if (done_tmo_i)     state_d = ST_TMO;
        else if (done_ok_i) state_d = ST_READ;
      end
      ST_TMO:  if (we_i && cmd_byte == CMD_RST) state_d = ST_READ;
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_READ;
      tgt_idx_o  <= '0;
      tgt_data_o <= '0;
    end else begin
      state_q <= state_d;
      if (start_o) begin
        tgt_idx_o  <= addr_i[ADDR_W-1:1];
        tgt_data_o <= wdata_i;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/flash_prog_timer.sv
module flash_prog_timer #(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PROG_CYCLES  = 64,
  parameter int unsigned LIMIT_CYCLES = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              running_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  output logic              done_ok_o,
  output logic              done_tmo_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] OK_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(LIMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             needs_set;

  // a 1 requested where the cell holds 0 can never verify
  assign needs_set  = |(new_i & ~old_i);
  assign done_ok_o  = running_i && !needs_set && (cnt_q == OK_LAST);
  assign done_tmo_o = running_i && needs_set && (cnt_q == TMO_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (running_i) cnt_q <= cnt_q + 1'b1;
    else                cnt_q <= '0;
  end
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_a_i,
  input  logic [IDX_W-1:0]  ridx_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '1;
      else if (we_i && widx_i == IDX_W'(i))        mem_q[i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/flash_status_rd.sv
module flash_status_rd
  import flash_prog_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              start_i,
  input  fsm_e              state_i,
  input  logic              poll_src_i,
  input  logic [DATA_W-1:0] arr_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tog_o
);
  logic              tog_q;
  logic [DATA_W-1:0] flags;
  logic              in_flags;

  assign in_flags = (state_i == ST_RUN) || (state_i == ST_TMO);

  always_comb begin
    flags           = '0;
    flags[BIT_POLL] = ~poll_src_i;
    flags[BIT_TOG]  = tog_q;
    flags[BIT_TMO]  = (state_i == ST_TMO);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (start_i)                          tog_q <= 1'b0;
      else if (re_i && state_i == ST_RUN)   tog_q <= ~tog_q;
      if (re_i) rdata_o <= in_flags ? flags : arr_word_i;
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/flash_prog_top.sv
module flash_prog_top
  import flash_prog_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned PROG_CYCLES  = 64,
  parameter int unsigned LIMIT_CYCLES = 512,
  parameter int unsigned UNLOCK_A     = 20,
  parameter int unsigned UNLOCK_B     = 10,
  parameter int unsigned IDX_W        = $clog2(DEPTH),
  parameter int unsigned ADDR_W       = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  fsm_e              state_q;
  logic              start, done_ok, done_tmo, tog_q;
  logic [IDX_W-1:0]  tgt_idx_q;
  logic [DATA_W-1:0] tgt_data_q, arr_bus, arr_old, arr_wdata;
  logic              arr_we;

  assign busy_o    = (state_q == ST_RUN);
  assign arr_we    = done_ok || done_tmo;
  assign arr_wdata = arr_old & tgt_data_q;

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_fsm (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .done_ok_i(done_ok), .done_tmo_i(done_tmo),
    .state_o(state_q), .start_o(start),
    .tgt_idx_o(tgt_idx_q), .tgt_data_o(tgt_data_q)
  );

  flash_prog_timer #(
    .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES), .LIMIT_CYCLES(LIMIT_CYCLES)
  ) u_timer (
    .clk_i, .rst_ni, .running_i(busy_o),
    .old_i(arr_old), .new_i(tgt_data_q),
    .done_ok_o(done_ok), .done_tmo_o(done_tmo)
  );

  flash_word_array #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_array (
    .clk_i, .rst_ni, .we_i(arr_we), .widx_i(tgt_idx_q), .wdata_i(arr_wdata),
    .ridx_a_i(addr_i[ADDR_W-1:1]), .ridx_b_i(tgt_idx_q),
    .rdata_a_o(arr_bus), .rdata_b_o(arr_old)
  );

  flash_status_rd #(
    .DATA_W(DATA_W)
  ) u_status (
    .clk_i, .rst_ni, .re_i, .start_i(start), .state_i(state_q),
    .poll_src_i(tgt_data_q[BIT_POLL]), .arr_word_i(arr_bus),
    .rdata_o, .tog_o(tog_q)
  );
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned LIMIT_CYCLES = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o,
  input fsm_e              state_q,
  input logic              tog_q,
  input logic [DATA_W-1:0] tgt_data_q
);
  localparam int unsigned CW = $clog2(LIMIT_CYCLES + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  p_start_on_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(we_i) && !$past(addr_i[0]));

  p_odd_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TGT && we_i && addr_i[0]) |=> !busy_o);

  p_busy_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_len < CW'(LIMIT_CYCLES));

  p_read_registered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  p_tog_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TMO && $past(state_q == ST_TMO)) |-> $stable(tog_q));

  p_writes_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(tgt_data_q));
endmodule

bind flash_prog_top flash_prog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT_CYCLES(LIMIT_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
  .busy_o(busy_o), .rdata_o(rdata_o), .state_q(state_q), .tog_q(tog_q),
  .tgt_data_q(tgt_data_q)
);

// File: tb/flash_prog_top_bench.sv
module flash_prog_top_bench;
  localparam int unsigned PROG  = 20;
  localparam int unsigned LIMIT = 60;
  localparam logic [4:0]  UA = 5'h14;
  localparam logic [4:0]  UB = 5'h0A;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] rdata;
  logic        busy;
  logic        re_d;
  int          checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  flash_prog_top #(
    .DEPTH(16), .DATA_W(16), .PROG_CYCLES(PROG), .LIMIT_CYCLES(LIMIT),
    .UNLOCK_A(20), .UNLOCK_B(10)
  ) u_flash_prog_top (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .busy_o(busy)
  );

  function automatic logic [15:0] stat(logic b7, logic tog, logic tmo);
    return {8'h00, ~b7, tog, tmo, 5'b0};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) re_d <= 1'b0; else re_d <= re;

  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  // all tasks start and end on a negedge
  task automatic wr(logic [4:0] a, logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] e, string tag);
    addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic prog(logic [4:0] a, logic [15:0] d);
    wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h00A0); wr(a, d);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rdata in reset", rdata, 16'h0000);
    check("R10 busy in reset", {15'b0, busy}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(5'h00, 16'hFFFF, "R10 erased after reset");
    rd(5'h04, 16'hFFFF, "R11 read mode word 2");

    // R1 exact busy length
    prog(5'h04, 16'h1234);
    check("R1 busy after 4th write", {15'b0, busy}, 16'h0001);
    repeat (PROG - 1) @(negedge clk);
    check("R1 busy in last cycle", {15'b0, busy}, 16'h0001);
    @(negedge clk);
    check("R1 busy ends after PROG_CYCLES", {15'b0, busy}, 16'h0000);
    rd(5'h04, 16'h1234, "R11 programmed word");

    // R2 broken sequence
    wr(UA, 16'h00AA); wr(UB, 16'h0055); wr(UA, 16'h0080); wr(5'h06, 16'h0000);
    check("R2 no start", {15'b0, busy}, 16'h0000);
    rd(5'h06, 16'hFFFF, "R2 no side effect");
    wr(UA, 16'h00AA); wr(UA, 16'h0055); wr(UA, 16'h00A0); wr(5'h06, 16'h0000);
    check("R2 wrong address no start", {15'b0, busy}, 16'h0000);
    rd(5'h06, 16'hFFFF, "R2 wrong address no side effect");

    // R3 odd target
    prog(5'h09, 16'h0000);
    check("R3 odd target busy", {15'b0, busy}, 16'h0000);
    rd(5'h08, 16'hFFFF, "R3 odd target not programmed");

    // R4/R6/R7/R9 subset program with reads and writes while busy
    prog(5'h04, 16'h1030);
    rd(5'h04, stat(1'b0, 1'b0, 1'b0), "R6 status first read");
    rd(5'h04, stat(1'b0, 1'b1, 1'b0), "R7 toggle second read");
    rd(5'h00, stat(1'b0, 1'b0, 1'b0), "R7 toggle third read");
    prog(5'h08, 16'h0000);
    wait_idle();
    rd(5'h08, 16'hFFFF, "R9 write while busy ignored");
    rd(5'h04, 16'h1030, "R4 AND result");

    // R5/R8 timeout
    prog(5'h04, 16'h00F0);
    rd(5'h04, stat(1'b1, 1'b0, 1'b0), "R6 status bit7 inverted");
    rd(5'h04, stat(1'b1, 1'b1, 1'b0), "R7 toggle");
    repeat (LIMIT - 3) @(negedge clk);
    check("R5 busy at limit-1", {15'b0, busy}, 16'h0001);
    @(negedge clk);
    check("R5 busy ends at limit", {15'b0, busy}, 16'h0000);
    rd(5'h04, stat(1'b1, 1'b0, 1'b1), "R5 timeout flag");
    rd(5'h04, stat(1'b1, 1'b0, 1'b1), "R8 toggle frozen");
    wr(5'h00, 16'h00AA);
    rd(5'h00, stat(1'b1, 1'b0, 1'b1), "R8 other write ignored");
    wr(5'h00, 16'h00F0);
    rd(5'h04, 16'h0030, "R5 AND stored after timeout");
    rd(5'h00, 16'hFFFF, "R8 read mode after reset command");

    // R10 hardware reset mid operation
    prog(5'h00, 16'h5555);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R10 busy cleared by reset", {15'b0, busy}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(5'h02, 16'hFFFF, "R10 read mode after reset");

    // read on the completion edge
    prog(5'h0C, 16'h0F0F);
    repeat (PROG - 1) @(negedge clk);
    rd(5'h0C, stat(1'b0, 1'b0, 1'b0), "R6 read on completion edge");
    check("R1 busy low after completion", {15'b0, busy}, 16'h0000);
    rd(5'h0C, 16'h0F0F, "R11 word after completion");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule